// File: doc/BRIEF.md
# Parameterised Hardware Stack Controller

This block keeps a last-in first-out stack in a small internal word memory and tracks its top with a stack pointer register. Each clock it accepts at most one operation: a push that carries a data word, or a pop whose word comes back one cycle later together with a valid strobe. It raises full and empty status levels, and it raises one-cycle error pulses for a push into a full stack, a pop from an empty stack, and a push and a pop requested in the same cycle.

Two compile-time parameters set the stack convention. `GROW_UP` selects whether the stack fills toward higher addresses (1) or toward lower addresses (0). `LAST_FULL` selects what the pointer marks. With 1 it marks the slot that holds the top word. With 0 it marks the slot that the next push will write. Each combination changes whether the pointer steps before or after the memory access. The pointer is brought out on the `sp` port so that logic outside the block can follow the chosen convention.

Top module: `stk_ctrl`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, the stack empties. `stk_empty`=1, `stk_full`=0, and `pop_valid`, `overflow`, `underflow` and `clash_err` are all 0.
- R2: A pop request without a push in the same cycle gives `pop_valid`=1 in the following cycle. When the stack held data, `pop_data` is the most recently pushed word that has not yet been popped. Operations may be issued back to back on every cycle.
- R3: A push request while `stk_full`=1 gives `overflow`=1 for exactly the following cycle. `sp` and the stored words stay unchanged.
- R4: A pop request without a push while `stk_empty`=1 gives `underflow`=1 and `pop_valid`=1 in the following cycle, with `pop_data`=0. `sp` stays unchanged.
- R5: When push and pop are requested in the same cycle, `clash_err`=1 in the following cycle. The push is carried out (or overflows), the pop is ignored, and `pop_valid` stays 0.
- R6: `sp` is PW=$clog2(DEPTH)+1 bits wide and is read modulo 2^PW. For count n of stored words: GROW_UP=1,LAST_FULL=1 gives `sp`=n-1; GROW_UP=1,LAST_FULL=0 gives `sp`=n; GROW_UP=0,LAST_FULL=1 gives `sp`=DEPTH-n; GROW_UP=0,LAST_FULL=0 gives `sp`=DEPTH-1-n.
- R7: The empty (reset) pointer lies one slot outside the storage in last-full mode: all ones when growing up, DEPTH when growing down. In next-empty mode it is the first slot to be filled: 0 when growing up, DEPTH-1 when growing down.
- R8: `stk_full`=1 exactly when DEPTH words are stored. `stk_empty`=1 exactly when none are stored. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Push request |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Pop request |
| pop_valid | output | 1 | Pop result valid (one cycle after request) |
| pop_data | output | DATA_W | Popped word, 0 on underflow |
| stk_full | output | 1 | Stack holds DEPTH words |
| stk_empty | output | 1 | Stack holds no words |
| sp | output | PW | Stack pointer |
| overflow | output | 1 | Push into full stack (pulse) |
| underflow | output | 1 | Pop from empty stack (pulse) |
| clash_err | output | 1 | Push and pop requested together (pulse) |

## Verification
A pointer that steps at the wrong moment, or in the wrong direction, shows on `sp` in the cycle after the operation. It shows again on `stk_full` or `stk_empty` once the count reaches a boundary. An access at the wrong slot is invisible until the affected word is popped, so the bench checks every pop result against a model, one cycle after each request. All four convention combinations are built at a depth of four and driven with the same stimulus. A fault confined to one combination therefore appears as a mismatch on that copy alone.

// File: rtl/stk_pkg.sv
// Package: shared types for the stack controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package stk_pkg;

    // Decoded action for one cycle
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } stk_act_e;

    // Pointer width for a given depth: one spare bit for the outside slot
    function automatic int ptr_width(input int depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/stk_req_decode.sv
// Module: stk_req_decode
// Turns the raw push/pop requests and the current full/empty levels into
// one accepted action and the error events for this cycle.
// Assumes full and empty come from the pointer register (no same-cycle loop).
module stk_req_decode
    import stk_pkg::*;
(
    input  logic     push_req,
    input  logic     pop_req,
    input  logic     full,
    input  logic     empty,
    output stk_act_e act,
    output logic     ovf_hit,
    output logic     udf_hit,
    output logic     clash_hit,
    output logic     pop_seen
);

    // Push wins over pop; blocked operations become error events
    always_comb begin
        act       = ACT_IDLE;
        ovf_hit   = 1'b0;
        udf_hit   = 1'b0;
        clash_hit = push_req && pop_req;
        pop_seen  = pop_req && !push_req;
        if (push_req) begin
            if (full) ovf_hit = 1'b1;
            else      act     = ACT_PUSH;
        end else if (pop_req) begin
            if (empty) udf_hit = 1'b1;
            else       act     = ACT_POP;
        end
    end

endmodule

// File: rtl/stk_ptr_unit.sv
// Module: stk_ptr_unit
// Holds the stack pointer and derives write/read slots, the stored-word
// count and the full/empty levels for the chosen growth direction and
// pointer convention.
// Assumes DEPTH >= 2 and that only one accepted action arrives per cycle.
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter bit GROW_UP   = 1'b1,
    parameter bit LAST_FULL = 1'b1,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_act_e      act,
    output logic [PW-1:0] ptr,
    output logic [AW-1:0] wr_slot,
    output logic [AW-1:0] rd_slot,
    output logic          full,
    output logic          empty
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] ONE_P   = PW'(1);
    localparam logic [PW-1:0] EMPTY_P =
        LAST_FULL ? (GROW_UP ? {PW{1'b1}} : DEPTH_P)
                  : (GROW_UP ? {PW{1'b0}} : DEPTH_P - ONE_P);

    logic [PW-1:0] fwd;
    logic [PW-1:0] back;
    logic [PW-1:0] occ;
    logic [PW-1:0] ptr_n;

    // One step toward and one step against the growth direction
    generate
        if (GROW_UP) begin : g_up
            assign fwd  = ptr + ONE_P;
            assign back = ptr - ONE_P;
        end else begin : g_down
            assign fwd  = ptr - ONE_P;
            assign back = ptr + ONE_P;
        end
    endgenerate

    // Count of stored words, read off the pointer for each variant
    generate
        if (GROW_UP && LAST_FULL) begin : g_occ_ul
            assign occ = ptr + ONE_P;
        end else if (GROW_UP) begin : g_occ_un
            assign occ = ptr;
        end else if (LAST_FULL) begin : g_occ_dl
            assign occ = DEPTH_P - ptr;
        end else begin : g_occ_dn
            assign occ = DEPTH_P - ONE_P - ptr;
        end
    endgenerate

    // Slot order: last-full steps before writing, next-empty after
    generate
        if (LAST_FULL) begin : g_lf_slots
            assign wr_slot = fwd[AW-1:0];
            assign rd_slot = ptr[AW-1:0];
        end else begin : g_ne_slots
            assign wr_slot = ptr[AW-1:0];
            assign rd_slot = back[AW-1:0];
        end
    endgenerate

    assign full  = (occ == DEPTH_P);
    assign empty = (occ == '0);

    // Next pointer from the accepted action
    always_comb begin
        case (act)
            ACT_PUSH: ptr_n = fwd;
            ACT_POP:  ptr_n = back;
            default:  ptr_n = ptr;
        endcase
    end

    // Pointer register with synchronous reset to the empty position
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= EMPTY_P;
        else        ptr <= ptr_n;
    end

    p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(act) == ACT_PUSH |-> occ == $past(occ) + ONE_P);

    p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(act) == ACT_POP |-> occ + ONE_P == $past(occ));

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(act) == ACT_IDLE |-> $stable(ptr));

    p_levels_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P);

endmodule

// File: rtl/stk_store.sv
// Module: stk_store
// Word memory for the stack with one write port and a registered read port.
// The read register loads zero whenever no read is enabled.
// Assumes the slot indices stay below DEPTH when enabled.
module stk_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_slot,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the pushed word into its slot
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot] <= wr_data;
    end

    // Capture the popped word, or zero when nothing is read
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_slot];
        else            rd_data <= '0;
    end

endmodule

// File: rtl/stk_ctrl.sv
// Module: stk_ctrl (top)
// Hardware stack controller: decodes push/pop requests, moves the stack
// pointer by the chosen convention, stores words and returns pops one
// cycle later with error pulses for overflow, underflow and clashes.
// Assumes DEPTH >= 2 and a single clock domain.
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 4,
    parameter bit GROW_UP   = 1'b1,
    parameter bit LAST_FULL = 1'b1,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              stk_full,
    output logic              stk_empty,
    output logic [PW-1:0]     sp,
    output logic              overflow,
    output logic              underflow,
    output logic              clash_err
);

    stk_act_e      act;
    logic          ovf_hit;
    logic          udf_hit;
    logic          clash_hit;
    logic          pop_seen;
    logic [AW-1:0] wr_slot;
    logic [AW-1:0] rd_slot;

    stk_req_decode u_dec (
        .push_req  (push_req),
        .pop_req   (pop_req),
        .full      (stk_full),
        .empty     (stk_empty),
        .act       (act),
        .ovf_hit   (ovf_hit),
        .udf_hit   (udf_hit),
        .clash_hit (clash_hit),
        .pop_seen  (pop_seen)
    );

    stk_ptr_unit #(
        .DEPTH     (DEPTH),
        .GROW_UP   (GROW_UP),
        .LAST_FULL (LAST_FULL)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .ptr     (sp),
        .wr_slot (wr_slot),
        .rd_slot (rd_slot),
        .full    (stk_full),
        .empty   (stk_empty)
    );

    stk_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (act == ACT_PUSH),
        .wr_slot (wr_slot),
        .wr_data (push_data),
        .rd_en   (act == ACT_POP),
        .rd_slot (rd_slot),
        .rd_data (pop_data)
    );

    // Register the per-cycle events into one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            clash_err <= 1'b0;
        end else begin
            pop_valid <= pop_seen;
            overflow  <= ovf_hit;
            underflow <= udf_hit;
            clash_err <= clash_hit;
        end
    end

    p_pop_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_req |=> pop_valid);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && stk_full |=> overflow && $stable(sp));

    p_underflow_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> pop_valid && pop_data == '0);

    p_clash_drops_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && pop_req |=> clash_err && !pop_valid);

    p_pulse_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |-> pop_data == '0);

endmodule

// File: tb/tb_stk_ctrl.sv
// Bench: drives all four stack conventions at depth 4 with one stimulus
// and compares each copy against an arithmetic model of the stack.
module tb_stk_ctrl;

    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] push_data = '0;

    logic          v_valid [4];
    logic [DW-1:0] v_data  [4];
    logic          v_full  [4];
    logic          v_empty [4];
    logic [PW-1:0] v_sp    [4];
    logic          v_ovf   [4];
    logic          v_udf   [4];
    logic          v_clash [4];

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // cfg bit0 = grow up, bit1 = last full
    generate
        for (genvar g = 0; g < 4; g++) begin : g_cfg
            stk_ctrl #(
                .DATA_W    (DW),
                .DEPTH     (DEPTH),
                .GROW_UP   (g[0]),
                .LAST_FULL (g[1])
            ) dut (
                .clk       (clk),
                .rst_n     (rst_n),
                .push_req  (push_req),
                .push_data (push_data),
                .pop_req   (pop_req),
                .pop_valid (v_valid[g]),
                .pop_data  (v_data[g]),
                .stk_full  (v_full[g]),
                .stk_empty (v_empty[g]),
                .sp        (v_sp[g]),
                .overflow  (v_ovf[g]),
                .underflow (v_udf[g]),
                .clash_err (v_clash[g])
            );
        end
    endgenerate

    logic [DW-1:0] mdl [DEPTH];
    int cnt = 0;

    function automatic logic [PW-1:0] sp_of(input int cfg, input int c);
        int v;
        case (cfg)
            0: v = DEPTH - 1 - c;
            1: v = c;
            2: v = DEPTH - c;
            default: v = c - 1;
        endcase
        return v[PW-1:0];
    endfunction

    task automatic chk(input string req, input string what, input int cfg,
                       input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s cfg=%0d cnt=%0d actual=%0h expected=%0h",
                     req, what, cfg, cnt, act, exp);
        end
    endtask

    task automatic check_levels(input string tag);
        for (int g = 0; g < 4; g++) begin
            chk("R6", {tag, " sp"}, g, int'(v_sp[g]), int'(sp_of(g, cnt)));
            chk("R8", {tag, " full"}, g, int'(v_full[g]), int'(cnt == DEPTH));
            chk("R8", {tag, " empty"}, g, int'(v_empty[g]), int'(cnt == 0));
        end
    endtask

    // One operation: drive at negedge, check the results at the next negedge
    task automatic step(input bit pu, input bit po, input logic [DW-1:0] d);
        bit e_valid, e_ovf, e_udf, e_clash;
        logic [DW-1:0] e_data;
        e_clash = pu && po;
        e_valid = po && !pu;
        e_ovf   = pu && cnt == DEPTH;
        e_udf   = e_valid && cnt == 0;
        e_data  = (e_valid && cnt > 0) ? mdl[cnt-1] : '0;
        push_req  = pu;
        pop_req   = po;
        push_data = d;
        if (pu && cnt < DEPTH) begin
            mdl[cnt] = d;
            cnt++;
        end else if (e_valid && cnt > 0) begin
            cnt--;
        end
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        for (int g = 0; g < 4; g++) begin
            chk("R2", "pop_valid", g, int'(v_valid[g]), int'(e_valid));
            chk("R2", "pop_data", g, int'(v_data[g]), int'(e_data));
            chk("R3", "overflow", g, int'(v_ovf[g]), int'(e_ovf));
            chk("R4", "underflow", g, int'(v_udf[g]), int'(e_udf));
            chk("R5", "clash_err", g, int'(v_clash[g]), int'(e_clash));
        end
        check_levels("step");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 / R7: reset state and empty pointer per convention
        for (int g = 0; g < 4; g++) begin
            chk("R1", "reset pop_valid", g, int'(v_valid[g]), 0);
            chk("R1", "reset flags", g,
                int'(v_ovf[g] | v_udf[g] | v_clash[g]), 0);
        end
        chk("R7", "empty sp up/last-full", 3, int'(v_sp[3]), (1 << PW) - 1);
        chk("R7", "empty sp up/next-empty", 1, int'(v_sp[1]), 0);
        chk("R7", "empty sp down/last-full", 2, int'(v_sp[2]), DEPTH);
        chk("R7", "empty sp down/next-empty", 0, int'(v_sp[0]), DEPTH - 1);
        check_levels("R1 reset");
        rst_n = 1'b1;
        // Fill, overflow, clash while full (R3, R5)
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(8'h11 * (i + 1)));
        step(1'b1, 1'b0, 8'hEE);
        step(1'b1, 1'b1, 8'hDD);
        // Drain, then underflow and clash on empty (R2, R4, R5)
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        step(1'b1, 1'b1, 8'h5A);
        step(1'b0, 1'b1, 8'h00);
        // Mixed back-to-back sweep
        for (int i = 0; i < 600; i++) begin
            int r;
            r = (i * 37 + i / 50 * 3 + 11) % 9;
            step(r < 4, r >= 3 && r < 8, DW'(i * 13 + 5));
        end
        // Mid-run reset returns every copy to empty (R1)
        step(1'b1, 1'b0, 8'hA5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cnt = 0;
        check_levels("R1 re-reset");
        step(1'b0, 1'b1, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule